// File: doc/BRIEF.md
# Privileged Cycle Counter with Guarded Access

This block keeps a 64-bit count of core clock cycles. A processor core can reach the count in two ways. The first is a model-specific-register style port that reads or writes the full 64-bit value. The second is a dedicated read-counter request that returns the value split into a high half and a low half.

Every access is checked against the core's operating mode, its current privilege level and a timestamp-disable control bit. An access that is not permitted returns no data. Instead it raises a one-cycle fault pulse that carries a fault code.

All results and faults are registered. A request sampled at a clock edge is answered during the following cycle. The returned value is the count as it stood just before that edge.

Top module: `tsc_guard`

## Requirements
- R1: After reset the counter is zero, and it then advances by one on every clock. From all-ones it wraps to zero without any fault pulse.
- R2: An accepted model-register read at address 0x10 places the full count on `msr_rdata_o` and pulses `ack_o` in the next cycle.
- R3: An accepted model-register write at address 0x10 loads `msr_wdata_i`. In the next cycle the count equals the written value, and it keeps counting upward from there. The write wins over the increment.
- R4: A model-register access at 0x10 is accepted only at privilege level 0 in real mode (`mode_i`=0) or protected mode (`mode_i`=1). Any other such access (privilege 1 to 3, or virtual-8086 mode, `mode_i`=2) pulses `fault_o` with code GP (2'b01), returns no data and leaves the count advancing undisturbed.
- R5: A model-register request at any address other than 0x10 has no effect: no `ack_o`, no `fault_o`, no change to any result output and no disturbance of the count.
- R6: An accepted read-counter request puts bits 63:32 of the count on `rd_hi_o` and bits 31:0 on `rd_lo_o`, with an `ack_o` pulse in the next cycle. Two reads on consecutive edges differ by exactly one.
- R7: With `ts_dis_i`=1, a read-counter request in protected mode at privilege level 1 to 3 pulses `fault_o` with code GP (2'b01), which stands for a general-protection fault with error code zero. The result outputs do not change.
- R8: With `ts_dis_i`=0, a read-counter request in protected mode succeeds at every privilege level. With `ts_dis_i`=1 it succeeds at privilege level 0.
- R9: A read-counter request in real mode or virtual-8086 mode pulses `fault_o` with code UD (2'b10), the invalid-opcode fault, and returns no data.
- R10: `ack_o` and `fault_o` are single-cycle pulses and are never high together. `fault_code_o` is 2'b00 whenever `fault_o` is low. The result outputs hold their value in every cycle that follows a non-accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the counter advances on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode: 0 real, 1 protected, 2 virtual-8086 |
| cpl_i | input | 2 | Current privilege level |
| ts_dis_i | input | 1 | Timestamp-disable control bit |
| msr_req_i | input | 1 | Model-register access request |
| msr_we_i | input | 1 | 1 for a write, 0 for a read |
| msr_addr_i | input | 32 | Model-register address |
| msr_wdata_i | input | 64 | Value to load on a write |
| rd_req_i | input | 1 | Read-counter request |
| ack_o | output | 1 | Pulse: the previous request was accepted |
| fault_o | output | 1 | Pulse: the previous request was rejected |
| fault_code_o | output | 2 | 2'b01 GP, 2'b10 UD, 2'b00 none |
| msr_rdata_o | output | 64 | Count returned by a model-register read |
| rd_hi_o | output | 32 | Upper half returned by a read-counter request |
| rd_lo_o | output | 32 | Lower half returned by a read-counter request |

## Verification
The assertions assume that the core issues at most one request per cycle, so a model-register request and a read-counter request never arrive together. They also assume that `mode_i` never takes the unused value 3. The stimulus issues one request at a time and only drives the modes 0, 1 and 2. It sweeps privilege levels and both settings of the timestamp-disable bit across each mode. It also places writes and reads back to back so that the write-over-increment priority and the wrap from all-ones to zero are both exercised.

// File: rtl/tsc_guard.sv
module tsc_guard #(
  parameter int          CNT_W    = 64,
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] TSC_ADDR = 32'h10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode_i,
  input  logic [1:0]          cpl_i,
  input  logic                ts_dis_i,
  input  logic                msr_req_i,
  input  logic                msr_we_i,
  input  logic [ADDR_W-1:0]   msr_addr_i,
  input  logic [CNT_W-1:0]    msr_wdata_i,
  input  logic                rd_req_i,
  output logic                ack_o,
  output logic                fault_o,
  output logic [1:0]          fault_code_o,
  output logic [CNT_W-1:0]    msr_rdata_o,
  output logic [CNT_W/2-1:0]  rd_hi_o,
  output logic [CNT_W/2-1:0]  rd_lo_o
);

  localparam int          HALF_W  = CNT_W / 2;
  localparam logic [1:0]  M_REAL  = 2'd0;
  localparam logic [1:0]  M_PROT  = 2'd1;
  localparam logic [1:0]  M_V86   = 2'd2;
  localparam logic [1:0]  FC_NONE = 2'b00;
  localparam logic [1:0]  FC_GP   = 2'b01;
  localparam logic [1:0]  FC_UD   = 2'b10;

  logic [CNT_W-1:0] cnt;

  wire ring0   = (cpl_i == 2'd0);
  wire hit     = msr_req_i && (msr_addr_i == TSC_ADDR[ADDR_W-1:0]);
  wire msr_ok  = ring0 && (mode_i == M_REAL || mode_i == M_PROT);
  wire rd_ok   = (mode_i == M_PROT) && (!ts_dis_i || ring0);
  wire wr_acc  = hit && msr_we_i && msr_ok;
  wire mrd_acc = hit && !msr_we_i && msr_ok;
  wire rd_acc  = rd_req_i && rd_ok;
  wire msr_bad = hit && !msr_ok;
  wire rd_bad  = rd_req_i && !rd_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cnt <= '0;
    else if (wr_acc) cnt <= msr_wdata_i;
    else             cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ack_o        <= 1'b0;
      fault_o      <= 1'b0;
      fault_code_o <= FC_NONE;
    end else begin
      ack_o        <= wr_acc || mrd_acc || rd_acc;
      fault_o      <= msr_bad || rd_bad;
      fault_code_o <= msr_bad ? FC_GP :
                      rd_bad  ? ((mode_i == M_PROT) ? FC_GP : FC_UD) : FC_NONE;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      msr_rdata_o <= '0;
      rd_hi_o     <= '0;
      rd_lo_o     <= '0;
    end else begin
      if (mrd_acc) msr_rdata_o <= cnt;
      if (rd_acc) begin
        rd_hi_o <= cnt[CNT_W-1:HALF_W];
        rd_lo_o <= cnt[HALF_W-1:0];
      end
    end

  // input assumption: one request per cycle, legal mode
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(msr_req_i && rd_req_i) && mode_i != 2'd3);

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_acc |=> cnt == $past(cnt) + 1'b1);

  // R3
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> cnt == $past(msr_wdata_i));

  // R6
  rd_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> ack_o && {rd_hi_o, rd_lo_o} == $past(cnt));

  // R7
  tsd_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_i && ts_dis_i && mode_i == M_PROT && !ring0 |=> fault_o && fault_code_o == FC_GP);

  // R9
  rd_ud_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_i && (mode_i == M_REAL || mode_i == M_V86) |=> fault_o && fault_code_o == FC_UD);

  // R4
  msr_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && (mode_i == M_V86 || !ring0) |=> fault_o && fault_code_o == FC_GP && !ack_o);

  // R10
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_o && fault_o) && (fault_o || fault_code_o == FC_NONE));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(rd_hi_o) && $stable(rd_lo_o));

endmodule

// File: tb/sim_tsc_guard.sv
module sim_tsc_guard;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0, cpl = 0;
  logic tsd = 0, mreq = 0, mwe = 0, rreq = 0;
  logic [31:0] maddr = 32'h10;
  logic [63:0] mwdata = 0;
  logic ack, flt;
  logic [1:0] fc;
  logic [63:0] mrd;
  logic [31:0] hi, lo;

  always #5 clk = ~clk;

  tsc_guard u0 (.clk(clk), .rst_n(rst_n), .mode_i(mode), .cpl_i(cpl), .ts_dis_i(tsd),
    .msr_req_i(mreq), .msr_we_i(mwe), .msr_addr_i(maddr), .msr_wdata_i(mwdata),
    .rd_req_i(rreq), .ack_o(ack), .fault_o(flt), .fault_code_o(fc),
    .msr_rdata_o(mrd), .rd_hi_o(hi), .rd_lo_o(lo));

  int checks = 0, fails = 0;
  string tag = "R1";

  // behavioural reference
  logic [63:0] m_cnt, m_mrd, m_rd;
  logic m_ack, m_flt;
  logic [1:0] m_fc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_mrd = 0; m_rd = 0; m_ack = 0; m_flt = 0; m_fc = 0;
    end else begin
      logic [63:0] old;
      old = m_cnt;
      m_cnt = old + 64'd1;
      m_ack = 0; m_flt = 0; m_fc = 0;
      if (mreq && maddr == 32'h10) begin
        if (cpl == 0 && mode != 2) begin
          m_ack = 1;
          if (mwe) m_cnt = mwdata; else m_mrd = old;
        end else begin
          m_flt = 1; m_fc = 2'b01;
        end
      end
      if (rreq) begin
        if (mode != 1) begin m_flt = 1; m_fc = 2'b10; end
        else if (tsd && cpl != 0) begin m_flt = 1; m_fc = 2'b01; end
        else begin m_ack = 1; m_rd = old; end
      end
    end
  end

  task automatic chk(input string r, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(tag, "ack", {63'd0, ack}, {63'd0, m_ack});
    chk(tag, "fault", {63'd0, flt}, {63'd0, m_flt});
    chk(tag, "code", {62'd0, fc}, {62'd0, m_fc});
    chk(tag, "msr_rdata", mrd, m_mrd);
    chk(tag, "hi:lo", {hi, lo}, m_rd);
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] md, input logic [1:0] pl, input logic t);
    mode = md; cpl = pl; tsd = t; rreq = 1;
    @(negedge clk); rreq = 0;
  endtask

  task automatic msr(input logic [1:0] md, input logic [1:0] pl, input logic w,
                     input logic [31:0] a, input logic [63:0] d);
    mode = md; cpl = pl; mwe = w; maddr = a; mwdata = d; mreq = 1;
    @(negedge clk); mreq = 0; mwe = 0; maddr = 32'h10;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] l0;
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("R1", "reset ack", {63'd0, ack}, 64'd0);
    chk("R1", "reset hi:lo", {hi, lo}, 64'd0);
    rst_n = 1;
    idle(4);
    rd(1, 0, 0); // sampled count 4 at that edge
    chk("R1", "count after reset", {hi, lo}, 64'd4);

    tag = "R8"; rd(1, 3, 0); rd(1, 2, 0); rd(1, 0, 1);
    tag = "R7"; rd(1, 3, 1); rd(1, 1, 1);
    tag = "R9"; rd(0, 0, 0); rd(2, 3, 0); rd(0, 0, 1);
    chk("R9", "code", {62'd0, fc}, 64'd2);

    tag = "R2"; msr(0, 0, 0, 32'h10, 0); msr(1, 0, 0, 32'h10, 0);
    tag = "R3"; msr(1, 0, 1, 32'h10, 64'h1234_5678_0000_0100);
    rd(1, 0, 0);
    chk("R3", "written value read next", {hi, lo}, 64'h1234_5678_0000_0100);
    tag = "R4"; msr(1, 3, 1, 32'h10, 64'hdead); msr(2, 0, 1, 32'h10, 64'hbeef);
    msr(2, 0, 0, 32'h10, 0); msr(0, 1, 0, 32'h10, 0);
    tag = "R5"; msr(0, 0, 1, 32'h11, 64'h7); msr(0, 0, 0, 32'h0, 0);
    chk("R5", "no ack on other address", {63'd0, ack}, 64'd0);

    tag = "R1"; msr(0, 0, 1, 32'h10, 64'hffff_ffff_ffff_ffff);
    rd(1, 0, 0);
    chk("R1", "all ones", {hi, lo}, 64'hffff_ffff_ffff_ffff);
    rd(1, 0, 0);
    chk("R1", "wrap to zero", {hi, lo}, 64'd0);
    chk("R1", "no fault on wrap", {63'd0, flt}, 64'd0);

    tag = "R6"; msr(0, 0, 1, 32'h10, 64'h0000_0001_ffff_fffe);
    rd(1, 2, 0);
    chk("R6", "hi", {32'd0, hi}, 64'd1);
    chk("R6", "lo", {32'd0, lo}, 64'hffff_fffe);
    l0 = lo;
    rd(1, 2, 0);
    chk("R6", "back-to-back delta", {32'd0, lo - l0}, 64'd1);
    chk("R6", "carry into hi", {32'd0, hi}, 64'd1);
    rd(1, 2, 0);
    chk("R6", "carry into hi after lo wrap", {32'd0, hi}, 64'd2);

    tag = "R10"; rd(1, 3, 1); idle(2);
    chk("R10", "pulse ended", {63'd0, flt}, 64'd0);
    chk("R10", "code cleared", {62'd0, fc}, 64'd0);
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule